// File: doc/BRIEF.md
# Slave-Mode Video Sync Decoder

This block sits behind the pixel input of a video encoder that runs as a timing slave. It receives a horizontal sync, a field or vertical sync and an optional blank signal from an upstream source. From these it rebuilds the frame structure the encoder needs: which field is on air, where each field and frame begins, the current line number and whether the current line carries active picture. All sync pins are asynchronous to the 27 MHz pixel clock. Each is resynchronised and edge-detected before any decision is made.

A two-bit timing mode selects how the field pin is read. In mode 0 the field pin is ignored and lines simply run on. In mode 1 a field-pin toggle seen while horizontal sync is low starts a new frame. Mode 3 is the same with the horizontal sync level inverted. In mode 2 the pin is a vertical sync, and the level of horizontal sync at its falling edge tells the odd field from the even one. A standard select picks 525-line or 625-line geometry. When the blank input is disabled, the block blanks the vertical interval of that standard by itself.

Top module: `vid_sync_slave`

## Requirements
- R1: After reset, lineNum is 1, fieldId is 0 (odd field), frameStart, fieldStart and activeVideo are 0, with the sync pins idle (hsyncIn high, fieldIn low).
- R2: A change on hsyncIn, fieldIn or blankIn shows at the outputs on the third rising clock edge after the change. Two edges go to synchronisation and one to the output register.
- R3: Each falling edge of hsyncIn advances lineNum by one. A rising edge of hsyncIn alone leaves lineNum unchanged.
- R4: From the last line of the frame (525 when stdSel=0, 625 when stdSel=1), the next falling hsyncIn edge gives line 1 with fieldId 0. Reaching the second-field start line by counting sets fieldId to 1.
- R5: In timingMode=1, a rise or fall of fieldIn while hsyncIn is low starts a frame: lineNum becomes 1, fieldId 0, and frameStart and fieldStart pulse. The same edge while hsyncIn is high starts the second field: lineNum becomes the second-field start line, fieldId 1, and only fieldStart pulses.
- R6: timingMode=3 behaves like timingMode=1 with the hsyncIn levels swapped. A frame starts on a fieldIn edge while hsyncIn is high, and the second field starts on a fieldIn edge while hsyncIn is low.
- R7: In timingMode=2, a falling fieldIn while hsyncIn is low starts a frame (odd field), and a falling fieldIn while hsyncIn is high starts the even field. A rising fieldIn has no effect.
- R8: In timingMode=0, edges on fieldIn produce no strobe and leave lineNum and fieldId unchanged.
- R9: The second field starts at line 264 when stdSel=0 and at line 314 when stdSel=1.
- R10: With blankEn=0, activeVideo is 1 only on lines 22..262 and 285..524 (stdSel=0) or on lines 23..310 and 336..623 (stdSel=1). It is 0 on every other line.
- R11: With blankEn=1, activeVideo follows the level of blankIn (1 = active picture, 0 = blanked) whatever the line number.
- R12: frameStart and fieldStart are high for a single clock per qualifying fieldIn edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| timingMode | input | 2 | Field-pin interpretation, 0..3 |
| stdSel | input | 1 | 0 = 525-line, 1 = 625-line geometry |
| blankEn | input | 1 | 1 = use blankIn, 0 = automatic vertical blanking |
| hsyncIn | input | 1 | External horizontal sync, active low |
| fieldIn | input | 1 | External field or vertical sync |
| blankIn | input | 1 | External blank, high during active picture |
| fieldId | output | 1 | 0 = odd/first field, 1 = even/second field |
| frameStart | output | 1 | One-clock pulse at a frame start |
| fieldStart | output | 1 | One-clock pulse at any field start |
| lineNum | output | 10 | Current line, 1-based |
| activeVideo | output | 1 | 1 while the line carries picture |

## Verification
Every pin-driven result is due on the third rising edge after the bench changes a pin. The bench therefore drives on a falling edge, waits three rising edges and samples on the next falling edge. It samples one falling edge later to confirm that each strobe has already dropped. Configuration inputs reach the registers after a single edge, so the bench settles them well before the edge under test. It also changes the field pin only while timing mode 0 is selected, so that setting up a pin level never produces an edge of its own. Line-count results are read after each horizontal pulse has fully settled, which makes the counts independent of pulse width.

// File: rtl/vss_pkg.sv
package vss_pkg;

  typedef enum logic [1:0] {
    TM_FREE     = 2'd0,
    TM_FLD_LOW  = 2'd1,
    TM_VS_PHASE = 2'd2,
    TM_FLD_HIGH = 2'd3
  } tmode_e;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic lineAdv;
    logic oddGo;
    logic evenGo;
    logic blankLvl;
  } strobe_t;

endpackage

// File: rtl/vss_sync.sv
module vss_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab, last;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
        last <= RST_VAL[i];
      end else begin
        meta <= din[i];
        stab <= meta;
        last <= stab;
      end
    end
    assign dout[i]  = stab;
    assign dprev[i] = last;
  end

endmodule

// File: rtl/vss_ctrl.sv
module vss_ctrl
  import vss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic       hsyncIn,
  input  logic       fieldIn,
  input  logic       blankIn,
  output strobe_t    stb
);

  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE = 3'b001; // blank low, field low, hsync high

  logic [NPIN-1:0] pinNow, pinOld;

  vss_sync #(.W(NPIN), .RST_VAL(IDLE)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .din   ({blankIn, fieldIn, hsyncIn}),
    .dout  (pinNow),
    .dprev (pinOld)
  );

  logic hsLvl, hsFall, fldEdge, fldFall;
  assign hsLvl   = pinNow[0];
  assign hsFall  = pinOld[0] & ~pinNow[0];
  assign fldEdge = pinOld[1] ^ pinNow[1];
  assign fldFall = pinOld[1] & ~pinNow[1];

  tmode_e mode;
  assign mode = tmode_e'(cfgMode);

  always_comb begin
    stb          = '0;
    stb.lineAdv  = hsFall;
    stb.blankLvl = pinNow[2];
    unique case (mode)
      TM_FLD_LOW: begin
        stb.oddGo  = fldEdge & ~hsLvl;
        stb.evenGo = fldEdge &  hsLvl;
      end
      TM_FLD_HIGH: begin
        stb.oddGo  = fldEdge &  hsLvl;
        stb.evenGo = fldEdge & ~hsLvl;
      end
      TM_VS_PHASE: begin
        stb.oddGo  = fldFall & ~hsLvl;
        stb.evenGo = fldFall &  hsLvl;
      end
      default: begin
        stb.oddGo  = 1'b0;
        stb.evenGo = 1'b0;
      end
    endcase
  end

  // R7: a rising vertical sync never starts a field in the phase mode
  a_r7_rise_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mode == TM_VS_PHASE && pinNow[1] && !pinOld[1]) |-> !(stb.oddGo || stb.evenGo));

endmodule

// File: rtl/vss_dpath.sv
module vss_dpath
  import vss_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int N_LINES    = 525,
  parameter int P_LINES    = 625,
  parameter int N_EVEN     = 264,
  parameter int P_EVEN     = 314,
  parameter int N_A_FIRST  = 22,
  parameter int N_A_LAST   = 262,
  parameter int N_B_FIRST  = 285,
  parameter int N_B_LAST   = 524,
  parameter int P_A_FIRST  = 23,
  parameter int P_A_LAST   = 310,
  parameter int P_B_FIRST  = 336,
  parameter int P_B_LAST   = 623
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stdSel,
  input  logic              blankEn,
  input  strobe_t           stb,
  output logic [LINE_W-1:0] lineNum,
  output logic              fieldId,
  output logic              frameStart,
  output logic              fieldStart,
  output logic              activeVideo
);

  typedef logic [LINE_W-1:0] line_t;

  localparam line_t FIRST = line_t'(1);

  line_t lastLine, evenLine;
  line_t aFirst, aLast, bFirst, bLast;

  always_comb begin
    if (stdSel) begin
      lastLine = line_t'(P_LINES);
      evenLine = line_t'(P_EVEN);
      aFirst   = line_t'(P_A_FIRST);
      aLast    = line_t'(P_A_LAST);
      bFirst   = line_t'(P_B_FIRST);
      bLast    = line_t'(P_B_LAST);
    end else begin
      lastLine = line_t'(N_LINES);
      evenLine = line_t'(N_EVEN);
      aFirst   = line_t'(N_A_FIRST);
      aLast    = line_t'(N_A_LAST);
      bFirst   = line_t'(N_B_FIRST);
      bLast    = line_t'(N_B_LAST);
    end
  end

  line_t lineNext;
  logic  fieldNext, autoActive, activeNext;

  always_comb begin
    lineNext  = lineNum;
    fieldNext = fieldId;
    if (stb.oddGo) begin
      lineNext  = FIRST;
      fieldNext = 1'b0;
    end else if (stb.evenGo) begin
      lineNext  = evenLine;
      fieldNext = 1'b1;
    end else if (stb.lineAdv) begin
      if (lineNum >= lastLine) begin
        lineNext  = FIRST;
        fieldNext = 1'b0;
      end else begin
        lineNext = lineNum + FIRST;
        if (lineNext == evenLine) fieldNext = 1'b1;
      end
    end
  end

  assign autoActive = ((lineNext >= aFirst) && (lineNext <= aLast)) ||
                      ((lineNext >= bFirst) && (lineNext <= bLast));
  assign activeNext = blankEn ? stb.blankLvl : autoActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineNum     <= FIRST;
      fieldId     <= 1'b0;
      frameStart  <= 1'b0;
      fieldStart  <= 1'b0;
      activeVideo <= 1'b0;
    end else begin
      lineNum     <= lineNext;
      fieldId     <= fieldNext;
      frameStart  <= stb.oddGo;
      fieldStart  <= stb.oddGo | stb.evenGo;
      activeVideo <= activeNext;
    end
  end

  // R3: a lone horizontal sync edge advances the count by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineAdv && !stb.oddGo && !stb.evenGo && lineNum < lastLine)
    |=> (lineNum == $past(lineNum) + FIRST));

  // R4: count stays inside the frame
  a_r4_range: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum >= FIRST) && (lineNum <= lastLine));

endmodule

// File: rtl/vid_sync_slave.sv
module vid_sync_slave
  import vss_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int N_LINES = 525,
  parameter int P_LINES = 625,
  parameter int N_EVEN  = 264,
  parameter int P_EVEN  = 314
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        timingMode,
  input  logic              stdSel,
  input  logic              blankEn,
  input  logic              hsyncIn,
  input  logic              fieldIn,
  input  logic              blankIn,
  output logic              fieldId,
  output logic              frameStart,
  output logic              fieldStart,
  output logic [LINE_W-1:0] lineNum,
  output logic              activeVideo
);

  strobe_t stb;

  vss_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgMode (timingMode),
    .hsyncIn (hsyncIn),
    .fieldIn (fieldIn),
    .blankIn (blankIn),
    .stb     (stb)
  );

  vss_dpath #(
    .LINE_W  (LINE_W),
    .N_LINES (N_LINES),
    .P_LINES (P_LINES),
    .N_EVEN  (N_EVEN),
    .P_EVEN  (P_EVEN)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stdSel      (stdSel),
    .blankEn     (blankEn),
    .stb         (stb),
    .lineNum     (lineNum),
    .fieldId     (fieldId),
    .frameStart  (frameStart),
    .fieldStart  (fieldStart),
    .activeVideo (activeVideo)
  );

  // R5: a frame start always lands on line 1 of the odd field
  a_r5_frame_is_odd: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (fieldStart && !fieldId && lineNum == LINE_W'(1)));

  // R9: second field begins at the standard's start line
  a_r9_even_line: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && fieldId) |-> (lineNum == (stdSel ? LINE_W'(P_EVEN) : LINE_W'(N_EVEN))));

  // R8: free-running mode never raises a field strobe
  a_r8_mode0_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timingMode) == 2'd0) |-> !fieldStart);

  // R10: line 1 is always inside the vertical interval
  a_r10_first_blank: assert property (@(posedge clk) disable iff (!rstN)
    (!blankEn && !$past(blankEn) && lineNum == LINE_W'(1)) |-> !activeVideo);

endmodule

// File: tb/vid_sync_slave_tb.sv
module vid_sync_slave_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] timingMode = 2'd0;
  logic       stdSel = 1'b0;
  logic       blankEn = 1'b0;
  logic       hsyncIn = 1'b1;
  logic       fieldIn = 1'b0;
  logic       blankIn = 1'b0;
  logic       fieldId, frameStart, fieldStart, activeVideo;
  logic [9:0] lineNum;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  always #5 clk = ~clk;

  vid_sync_slave u_dut (
    .clk(clk), .rstN(rstN), .timingMode(timingMode), .stdSel(stdSel),
    .blankEn(blankEn), .hsyncIn(hsyncIn), .fieldIn(fieldIn), .blankIn(blankIn),
    .fieldId(fieldId), .frameStart(frameStart), .fieldStart(fieldStart),
    .lineNum(lineNum), .activeVideo(activeVideo)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: got=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", nChk + 1, nBad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nChk = nChk + 1;
    if (got != exp) begin
      nBad = nBad + 1;
      $display("FAIL %s: got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // n rising edges, then land on a falling edge
  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hsPulse(input int n);
    for (int k = 0; k < n; k++) begin
      hsyncIn = 1'b0;
      waitCyc(4);
      hsyncIn = 1'b1;
      waitCyc(4);
    end
  endtask

  // Set pin levels under mode 0, then make one fieldIn edge in mode m.
  // Returns on the falling edge after the third rising edge.
  task automatic fieldEdge(input logic [1:0] m, input logic hs, input logic rise, input logic sd);
    timingMode = 2'd0;
    stdSel     = sd;
    hsyncIn    = hs;
    fieldIn    = ~rise;
    waitCyc(6);
    timingMode = m;
    waitCyc(2);
    fieldIn = rise;
    waitCyc(3);
  endtask

  // mode, hs level, rise, std, expected line, expected field, expected frame
  localparam logic [16:0] VEC [10] = '{
    {2'd1, 1'b0, 1'b1, 1'b0, 10'd1,   1'b0, 1'b1},
    {2'd1, 1'b0, 1'b0, 1'b1, 10'd1,   1'b0, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b0, 10'd264, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1, 10'd314, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 10'd1,   1'b0, 1'b1},
    {2'd3, 1'b0, 1'b0, 1'b0, 10'd264, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1, 10'd314, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'd1,   1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1, 10'd314, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 10'd264, 1'b1, 1'b0}
  };

  initial begin
    int lineHold;
    logic fldHold;
    int seen;

    waitCyc(5);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 line", lineNum, 1);
    chk("R1 field", fieldId, 0);
    chk("R1 frameStart", frameStart, 0);
    chk("R1 fieldStart", fieldStart, 0);
    chk("R1 active", activeVideo, 0);

    // Table walk: R5 R6 R7 R9 with R2 timing and R12 pulse width
    for (int i = 0; i < 10; i++) begin
      fieldEdge(VEC[i][16:15], VEC[i][14], VEC[i][13], VEC[i][12]);
      chk($sformatf("R5/R6/R7 vec%0d line", i), lineNum, int'(VEC[i][11:2]));
      chk($sformatf("R9 vec%0d field", i), fieldId, VEC[i][1]);
      chk($sformatf("R2 vec%0d fieldStart", i), fieldStart, 1);
      chk($sformatf("R5 vec%0d frameStart", i), frameStart, VEC[i][0]);
      @(negedge clk);
      chk($sformatf("R12 vec%0d strobe low", i), fieldStart, 0);
    end

    // R8: mode 0 ignores field edges
    timingMode = 2'd0;
    stdSel = 1'b0;
    hsyncIn = 1'b0;
    waitCyc(6);
    lineHold = lineNum;
    fldHold  = fieldId;
    fieldIn  = ~fieldIn;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (fieldStart) seen = 1;
    end
    chk("R8 no strobe", seen, 0);
    chk("R8 line kept", lineNum, lineHold);
    chk("R8 field kept", fieldId, fldHold);
    hsyncIn = 1'b1;
    waitCyc(4);

    // R7: rising vertical sync ignored
    timingMode = 2'd0;
    fieldIn = 1'b0;
    waitCyc(6);
    timingMode = 2'd2;
    waitCyc(2);
    lineHold = lineNum;
    fieldIn = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (fieldStart) seen = 1;
    end
    chk("R7 rise no strobe", seen, 0);
    chk("R7 rise line kept", lineNum, lineHold);

    // R3 counting from a frame start
    fieldEdge(2'd1, 1'b0, 1'b1, 1'b0);
    hsyncIn = 1'b1;
    waitCyc(4);
    timingMode = 2'd0;
    hsPulse(5);
    chk("R3 five lines", lineNum, 6);
    hsyncIn = 1'b0;
    waitCyc(6);
    chk("R3 falling edge", lineNum, 7);
    hsyncIn = 1'b1;
    waitCyc(6);
    chk("R3 rising ignored", lineNum, 7);

    // R10 automatic blanking, first field, 525 lines
    hsPulse(14);
    chk("R10 line21 line", lineNum, 21);
    chk("R10 line21 blank", activeVideo, 0);
    hsPulse(1);
    chk("R10 line22 active", activeVideo, 1);

    // R11 external blank
    blankEn = 1'b1;
    blankIn = 1'b0;
    waitCyc(4);
    chk("R11 low on active line", activeVideo, 0);
    fieldEdge(2'd1, 1'b0, 1'b1, 1'b0);
    blankIn = 1'b1;
    waitCyc(4);
    chk("R11 high on line 1", activeVideo, 1);
    blankEn = 1'b0;
    blankIn = 1'b0;
    hsyncIn = 1'b1;
    waitCyc(4);
    chk("R10 back to auto", activeVideo, 0);

    // R4, R9, R10: 525-line second field and wrap
    fieldEdge(2'd1, 1'b1, 1'b1, 1'b0);
    timingMode = 2'd0;
    chk("R9 NTSC even start", lineNum, 264);
    hsPulse(20);
    chk("R10 line284 blank", activeVideo, 0);
    hsPulse(1);
    chk("R10 line285 active", activeVideo, 1);
    hsPulse(240);
    chk("R4 last line", lineNum, 525);
    chk("R4 last field", fieldId, 1);
    hsPulse(1);
    chk("R4 wrap line", lineNum, 1);
    chk("R4 wrap field", fieldId, 0);
    hsPulse(262);
    chk("R4 line263 field", fieldId, 0);
    hsPulse(1);
    chk("R4 count to 264", lineNum, 264);
    chk("R4 field by count", fieldId, 1);

    // R4, R10: 625-line wrap and blanking
    fieldEdge(2'd1, 1'b1, 1'b1, 1'b1);
    timingMode = 2'd0;
    chk("R9 PAL even start", lineNum, 314);
    hsPulse(311);
    chk("R4 PAL last line", lineNum, 625);
    hsPulse(1);
    chk("R4 PAL wrap line", lineNum, 1);
    chk("R4 PAL wrap field", fieldId, 0);
    hsPulse(21);
    chk("R10 PAL line22 blank", activeVideo, 0);
    hsPulse(1);
    chk("R10 PAL line23 active", activeVideo, 1);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule